// File: doc/BRIEF.md
# Codec control serial write master

This block sends 16-bit write commands to one of two codec chips over a three-wire serial link: a serial clock, a serial data line and two active-low chip selects. A client offers a request made of a chip index, a 5-bit register address and an 8-bit data byte. The block takes the request when it is idle and assembles the frame. The two top bits carry the fixed device address `10`, followed by a constant write flag `1`, then the register address, then the data byte. The frame is shifted out most-significant bit first.

Every output line idles high. A transfer passes through these states:
- `ST_IDLE`: ready is high.
- `ST_LEAD`: all lines stay high for one phase.
- `ST_SELECT`: the chosen chip select is low for one phase.
- `ST_CLK_LO`, `ST_DAT_SET`, `ST_CLK_HI`: these three repeat once for each of the 16 bits. The clock goes low, then the bit is placed on the data line, then the clock rises and the codec samples the bit.
- `ST_TRAIL`: all lines return high together for one phase.
- Back to `ST_IDLE`, with a one-cycle done pulse.

The transitions are IDLE→LEAD on an accepted in-range request, LEAD→SELECT, SELECT→CLK_LO, CLK_LO→DAT_SET, DAT_SET→CLK_HI, CLK_HI→CLK_LO while bits remain, CLK_HI→TRAIL after the last bit, and TRAIL→IDLE. Each transition, except the one out of IDLE, happens when a phase of `PHASE_CYC` system clocks ends.

A chip index outside 0..`MAX_CHIP` is rejected. The block produces no bus activity, raises a one-cycle error pulse and keeps ready high.

Top module: `codec_ctl_ser_master`

## Requirements
- R1: After reset and whenever idle, the serial clock, the data line and both chip selects are high, ready is high, and done and error are low.
- R2: An accepted request produces exactly 16 rising clock edges. The data values sampled at those edges, most-significant bit first, are `{2'b10, 1'b1, reg[4:0], data[7:0]}`.
- R3: Chip index 0 drives chip select bit 0 low. Any nonzero in-range index drives chip select bit 1 low. The other select stays high throughout, and the chosen select is low for exactly 49 phases.
- R4: All lines stay high for the first phase after acceptance. The chosen select then falls and stays low for one phase before the first falling clock edge. So the select falls `PHASE_CYC` cycles after acceptance and the clock falls `2*PHASE_CYC` cycles after acceptance.
- R5: Each bit uses three phases of `PHASE_CYC` cycles: clock low with the data held, the data updated, and clock high. Data never changes while the clock is high and the chip select is steady.
- R6: After the last bit, the clock, the data and the chip select all go high on the same cycle and stay high for one phase. Done is reported `51*PHASE_CYC` cycles after acceptance.
- R7: Ready is low from the cycle after acceptance until the final idle phase ends, and it returns high together with done.
- R8: A request whose chip index exceeds `MAX_CHIP` causes a one-cycle error pulse one cycle later. Ready stays high and no line moves.
- R9: Changing the request fields after acceptance does not alter the frame or the chip select in use.
- R10: Done is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; a request is taken this cycle |
| req_chip | input | IDX_W | Target chip index |
| req_reg | input | 5 | Codec register address |
| req_data | input | 8 | Data byte |
| xfer_done | output | 1 | One-cycle pulse at the end of a transfer |
| req_err | output | 1 | One-cycle pulse for a rejected chip index |
| ser_clk | output | 1 | Serial clock, idles high |
| ser_dat | output | 1 | Serial data, idles high |
| ser_cs_n | output | 2 | Active-low chip selects |

## Verification
The assertions check properties on every cycle:
- the idle lines are all high while ready is high;
- the two chip selects are never low together;
- the clock is never low without a select;
- data is stable while the clock is high;
- ready falls after every in-range acceptance;
- an error pulse never coincides with bus activity;
- done lasts a single cycle.

Some behaviours only the directed scenarios can show. These are the frame contents and bit order, which select each chip index drives, the exact cycle offsets of the lead, select, bit and trail phases, the total transfer length, and the fact that fields changed after acceptance do not reach the frame.

// File: rtl/ccsm_pkg.sv
package ccsm_pkg;

    localparam int FRAME_W = 16;
    localparam int REG_W   = 5;
    localparam int DATA_W  = 8;

    localparam logic [1:0] DEV_ADDR = 2'b10;
    localparam logic       WR_FLAG  = 1'b1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SELECT,
        ST_CLK_LO,
        ST_DAT_SET,
        ST_CLK_HI,
        ST_TRAIL
    } ccsm_state_e;

    function automatic logic [FRAME_W-1:0] build_frame(
        input logic [REG_W-1:0]  reg_addr,
        input logic [DATA_W-1:0] wr_byte
    );
        return {DEV_ADDR, WR_FLAG, reg_addr, wr_byte};
    endfunction

endpackage

// File: rtl/ccsm_phase_timer.sv
module ccsm_phase_timer #(
    parameter int PHASE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic phase_end
);
    localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign phase_end = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold || phase_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ccsm_frame_shift.sv
module ccsm_frame_shift #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               shift,
    output logic               msb,
    output logic               last
);
    localparam int BCW = $clog2(FRAME_W);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME_W - 1);

    logic [FRAME_W-1:0] sr_q;
    logic [BCW-1:0]     bcnt_q;

    assign msb  = sr_q[FRAME_W-1];
    assign last = (bcnt_q == LAST_BIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            bcnt_q <= '0;
        end else if (load) begin
            sr_q   <= frame_in;
            bcnt_q <= '0;
        end else if (shift) begin
            sr_q   <= {sr_q[FRAME_W-2:0], 1'b0};
            bcnt_q <= bcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/codec_ctl_ser_master.sv
module codec_ctl_ser_master
    import ccsm_pkg::*;
#(
    parameter int PHASE_CYC = 4,
    parameter int IDX_W     = 3,
    parameter int MAX_CHIP  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IDX_W-1:0]  req_chip,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [DATA_W-1:0] req_data,
    output logic              xfer_done,
    output logic              req_err,
    output logic              ser_clk,
    output logic              ser_dat,
    output logic [1:0]        ser_cs_n
);
    localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(MAX_CHIP);
    localparam int N_CS = 2;

    ccsm_state_e state_q, nxt;

    logic accept, in_range, start, reject;
    logic phase_end, shift, bit_msb, bit_last;
    logic sel_q;
    logic clk_q, dat_q, done_q, err_q;
    logic [N_CS-1:0] cs_n_q;
    logic cs_active;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign in_range  = (req_chip <= MAX_IDX);
    assign start     = accept && in_range;
    assign reject    = accept && !in_range;
    assign shift     = (state_q == ST_CLK_HI) && phase_end;

    ccsm_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (state_q == ST_IDLE),
        .phase_end (phase_end)
    );

    ccsm_frame_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .frame_in (build_frame(req_reg, req_data)),
        .shift    (shift),
        .msb      (bit_msb),
        .last     (bit_last)
    );

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_IDLE:    if (start)     nxt = ST_LEAD;
            ST_LEAD:    if (phase_end) nxt = ST_SELECT;
            ST_SELECT:  if (phase_end) nxt = ST_CLK_LO;
            ST_CLK_LO:  if (phase_end) nxt = ST_DAT_SET;
            ST_DAT_SET: if (phase_end) nxt = ST_CLK_HI;
            ST_CLK_HI:  if (phase_end) nxt = bit_last ? ST_TRAIL : ST_CLK_LO;
            ST_TRAIL:   if (phase_end) nxt = ST_IDLE;
            default:                   nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= 1'b0;
        end else begin
            state_q <= nxt;
            if (start) sel_q <= (req_chip != '0);
        end
    end

    assign cs_active = (nxt == ST_SELECT) || (nxt == ST_CLK_LO) ||
                       (nxt == ST_DAT_SET) || (nxt == ST_CLK_HI);

    // Output register, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q  <= 1'b1;
            dat_q  <= 1'b1;
            cs_n_q <= '1;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            clk_q  <= !((nxt == ST_CLK_LO) || (nxt == ST_DAT_SET));
            if (nxt == ST_DAT_SET) begin
                dat_q <= bit_msb;
            end else if ((nxt != ST_CLK_LO) && (nxt != ST_CLK_HI)) begin
                dat_q <= 1'b1;
            end
            for (int g = 0; g < N_CS; g++) begin
                cs_n_q[g] <= !(cs_active && (int'(sel_q) == g));
            end
            done_q <= (state_q == ST_TRAIL) && phase_end;
            err_q  <= reject;
        end
    end

    assign ser_clk   = clk_q;
    assign ser_dat   = dat_q;
    assign ser_cs_n  = cs_n_q;
    assign xfer_done = done_q;
    assign req_err   = err_q;
endmodule

// File: rtl/ccsm_checker.sv
module ccsm_checker #(
    parameter int IDX_W    = 3,
    parameter int MAX_CHIP = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [IDX_W-1:0] req_chip,
    input logic             xfer_done,
    input logic             req_err,
    input logic             ser_clk,
    input logic             ser_dat,
    input logic [1:0]       ser_cs_n
);
    localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(MAX_CHIP);

    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ser_clk && ser_dat && ser_cs_n == 2'b11));

    assert_one_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ser_cs_n != 2'b00);

    assert_clk_needs_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_clk |-> (ser_cs_n != 2'b11));

    assert_data_steady_clk_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk) && ser_cs_n == $past(ser_cs_n)) |-> $stable(ser_dat));

    assert_ready_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_chip <= MAX_IDX) |=> !req_ready);

    assert_reject_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (req_ready && ser_cs_n == 2'b11 && ser_clk));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    assert_done_with_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> req_ready);
endmodule

bind codec_ctl_ser_master ccsm_checker #(.IDX_W(IDX_W), .MAX_CHIP(MAX_CHIP)) u_ccsm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_chip  (req_chip),
    .xfer_done (xfer_done),
    .req_err   (req_err),
    .ser_clk   (ser_clk),
    .ser_dat   (ser_dat),
    .ser_cs_n  (ser_cs_n)
);

// File: tb/test_codec_ctl_ser_master.sv
module test_codec_ctl_ser_master;
    localparam int PH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [2:0] req_chip = '0;
    logic [4:0] req_reg = '0;
    logic [7:0] req_data = '0;
    logic       xfer_done, req_err, ser_clk, ser_dat;
    logic [1:0] ser_cs_n;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    codec_ctl_ser_master #(.PHASE_CYC(PH), .IDX_W(3), .MAX_CHIP(3)) i_codec_ctl_ser_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_chip(req_chip), .req_reg(req_reg), .req_data(req_data),
        .xfer_done(xfer_done), .req_err(req_err), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .ser_cs_n(ser_cs_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(ser_clk && ser_dat && ser_cs_n == 2'b11, "R1 lines in reset",
            {ser_clk, ser_dat, ser_cs_n}, 4'hF);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(ser_clk && ser_dat && ser_cs_n == 2'b11, "R1 lines idle",
            {ser_clk, ser_dat, ser_cs_n}, 4'hF);
        chk(req_ready && !xfer_done && !req_err, "R1 ready/done/err",
            {req_ready, xfer_done, req_err}, 3'b100);
    endtask

    task automatic run_write(input logic [2:0] chip, input logic [4:0] r, input logic [7:0] d);
        logic [15:0] exp_frame = {2'b10, 1'b1, r, d};
        logic [15:0] frame = '0;
        int edges = 0, cs_low_cnt = 0, wrong_cs = 0;
        int f_cs = 0, f_clk_lo = 0, f_clk_hi = 0, f_dat_lo = 0, done_k = 0;
        int trail_bad = 0, ready_bad = 0;
        int sel = (chip != 0) ? 1 : 0;
        logic prev_clk = 1'b1;
        bit seen_lo = 0;
        @(negedge clk);
        req_valid = 1'b1; req_chip = chip; req_reg = r; req_data = d;
        @(posedge clk);
        #1;
        req_valid = 1'b0; req_chip = ~chip; req_reg = ~r; req_data = ~d;  // R9 scramble
        for (int k = 1; k <= 60 * PH; k++) begin
            @(negedge clk);
            if (ser_clk && !prev_clk) begin
                frame = {frame[14:0], ser_dat};
                edges++;
            end
            if (!ser_clk) seen_lo = 1;
            if (!ser_clk && f_clk_lo == 0) f_clk_lo = k;
            if (ser_clk && seen_lo && f_clk_hi == 0) f_clk_hi = k;
            if (!ser_dat && f_dat_lo == 0) f_dat_lo = k;
            if (ser_cs_n[sel] == 1'b0) begin
                cs_low_cnt++;
                if (f_cs == 0) f_cs = k;
            end
            if (ser_cs_n[1 - sel] == 1'b0) wrong_cs++;
            if (k > 50 * PH && k <= 51 * PH &&
                !(ser_clk && ser_dat && ser_cs_n == 2'b11)) trail_bad++;
            if (k <= 51 * PH && req_ready) ready_bad++;
            prev_clk = ser_clk;
            if (xfer_done) begin
                done_k = k;
                break;
            end
        end
        chk(frame == exp_frame, "R2/R9 frame", int'(frame), int'(exp_frame));
        chk(edges == 16, "R2 rising edges", edges, 16);
        chk(wrong_cs == 0 && cs_low_cnt == 49 * PH, "R3 select",
            cs_low_cnt + 1000 * wrong_cs, 49 * PH);
        chk(f_cs == PH + 1, "R4 select fall", f_cs, PH + 1);
        chk(f_clk_lo == 2 * PH + 1, "R4 first clock fall", f_clk_lo, 2 * PH + 1);
        chk(f_clk_hi == 4 * PH + 1, "R5 first clock rise", f_clk_hi, 4 * PH + 1);
        chk(f_dat_lo == 6 * PH + 1, "R5 data update phase", f_dat_lo, 6 * PH + 1);
        chk(trail_bad == 0, "R6 trail lines high", trail_bad, 0);
        chk(done_k == 51 * PH + 1, "R6 done timing", done_k, 51 * PH + 1);
        chk(ready_bad == 0 && req_ready, "R7 ready busy window", ready_bad, 0);
        @(negedge clk);
        chk(!xfer_done, "R10 done single cycle", xfer_done, 0);
    endtask

    task automatic test_reject(input logic [2:0] chip);
        int moved = 0;
        @(negedge clk);
        req_valid = 1'b1; req_chip = chip; req_reg = 5'h0A; req_data = 8'h55;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        chk(req_err, "R8 error pulse", req_err, 1);
        chk(req_ready, "R8 ready stays high", req_ready, 1);
        for (int k = 0; k < 3 * PH; k++) begin
            @(negedge clk);
            if (!(ser_clk && ser_dat && ser_cs_n == 2'b11) || req_err || !req_ready) moved++;
        end
        chk(moved == 0, "R8 no bus activity", moved, 0);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        test_reset();
        run_write(3'd0, 5'h1F, 8'hA5);
        run_write(3'd1, 5'h02, 8'h3C);
        run_write(3'd3, 5'h00, 8'hFF);
        test_reject(3'd5);
        run_write(3'd2, 5'h15, 8'h00);
        test_reject(3'd7);
        run_write(3'd0, 5'h0A, 8'h81);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule